// File: doc/BRIEF.md
# Two-Master Bus Arbiter with Lock Recovery

This block decides which of two masters may drive a shared synchronous bus: a primary processor and one alternate master. It drives one grant to each. On every rising clock edge it samples the processor's busy, lock and transfer-in-progress lines, the slave's acknowledge and error lines, and both request lines. When no one else asks for the bus, the grant stays parked on the processor.

The processor may not give up the bus when its grant is removed. It can start one more cycle when the grant falls on or after the edge that ends its current transfer, or while it is parked. The arbiter therefore removes the processor's grant first and samples busy on the next edge. A busy processor keeps the bus. A processor that begins a locked sequence inside this window gets its grant back at once. The alternate master is granted only after the processor is seen idle and unlocked. Between any two owners, every grant stays negated for at least `GAP_CYCLES` rising edges, so two masters never drive the bus together.

Top module: `bus_arbiter2`

## Requirements
- R1: One cycle after synchronous reset (`rst` high on a rising edge) is released, `cpu_grant` is 1 and `alt_grant` is 0.
- R2: `cpu_grant` and `alt_grant` are never 1 in the same cycle.
- R3: While `alt_req` is 0, or while `cpu_req` is 1, the grant stays on the processor.
- R4: When the processor holds the grant and an edge samples `alt_req`=1, `cpu_req`=0 and `cpu_lock`=0, `cpu_grant` goes to 0 after that edge, and `alt_grant` stays 0 for at least that cycle.
- R5: After the processor's grant is removed, `alt_grant` rises only after an edge that sampled `cpu_busy`=0 and `cpu_lock`=0. While `cpu_busy` stays 1, `alt_grant` stays 0, including after a transfer acknowledge or error.
- R6: If an edge samples `cpu_lock`=1 while the processor's grant is removed and the alternate master is not yet granted, `cpu_grant` is 1 after that edge and `alt_grant` stays 0.
- R7: When the alternate master owns the bus and an edge samples `alt_req`=0, both grants are 0 after that edge. `cpu_grant` returns once the dead gap has passed.
- R8: Before either grant rises after a change of owner, both grants have been 0 for at least `GAP_CYCLES` rising edges (default 1).
- R9: If `alt_req` falls, or `cpu_req` rises, while the processor's grant is removed and `cpu_busy` is 0, the grant returns to the processor.
- R10: While the processor holds the grant and `cpu_lock` is 1, the grant is not taken away even if `alt_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor asks to keep or take the bus |
| alt_req | input | 1 | Alternate master asks for the bus |
| cpu_busy | input | 1 | Processor is driving the bus |
| cpu_tip | input | 1 | Processor has a transfer in progress |
| cpu_lock | input | 1 | Processor is inside a locked sequence |
| slv_ack | input | 1 | Slave acknowledges the current transfer |
| slv_err | input | 1 | Slave ends the current transfer with an error |
| cpu_grant | output | 1 | Bus granted to the processor |
| alt_grant | output | 1 | Bus granted to the alternate master |

## Verification
The handover is driven with four patterns. In the first, the processor's grant falls while a transfer is still open, so the acknowledge arrives after the grant has gone. In the second, the acknowledge and the grant removal land on the same edge and busy stays high for a follow-on cycle. In the third, lock rises inside the window. In the fourth, busy is already low. Together these show whether the arbiter waits on busy rather than on the acknowledge, whether it re-grants on lock, and whether it moves straight to the alternate master when the processor is quiet. Cancelled requests, a competing processor request, a lock held over the request, and a series of back-to-back handovers check the return path and the dead gap.

// File: rtl/arb_pkg.sv
package arb_pkg;

  typedef enum logic [2:0] {
    ST_CPU   = 3'd0,
    ST_CHECK = 3'd1,
    ST_HELD  = 3'd2,
    ST_ALT   = 3'd3,
    ST_GAP   = 3'd4
  } arb_state_t;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_PARK   = 3'd1,
    PH_ACTIVE = 3'd2,
    PH_INDET  = 3'd3,
    PH_ALT    = 3'd4
  } bus_phase_t;

  function automatic bus_phase_t classify_phase(logic cg, logic ag, logic busy, logic tip);
    if (ag)                return PH_ALT;
    if (cg && busy && tip) return PH_ACTIVE;
    if (cg)                return PH_PARK;
    if (busy)              return PH_INDET;
    return PH_IDLE;
  endfunction

  function automatic logic transfer_ends(logic busy, logic tip, logic ack, logic err);
    return busy && tip && (ack || err);
  endfunction

  function automatic logic gap_met(int unsigned edges_before, int unsigned need);
    return (edges_before + 1) >= need;
  endfunction

endpackage

// File: rtl/bus_phase_tracker.sv
module bus_phase_tracker
  import arb_pkg::*;
(
  input  logic       cpu_grant,
  input  logic       alt_grant,
  input  logic       cpu_busy,
  input  logic       cpu_tip,
  input  logic       slv_ack,
  input  logic       slv_err,
  output bus_phase_t phase,
  output logic       term_edge
);

  always_comb begin
    phase     = classify_phase(cpu_grant, alt_grant, cpu_busy, cpu_tip);
    term_edge = transfer_ends(cpu_busy, cpu_tip, slv_ack, slv_err);
  end

endmodule

// File: rtl/dead_time_counter.sv
module dead_time_counter
  import arb_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic quiet,
  output logic gap_ok
);

  localparam int unsigned CW = $clog2(GAP_CYCLES + 1) + 1;
  localparam logic [CW-1:0] CMAX = CW'(GAP_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)             cnt_q <= '0;
    else if (!quiet)     cnt_q <= '0;
    else if (cnt_q != CMAX) cnt_q <= cnt_q + 1'b1;
  end

  always_comb gap_ok = quiet && gap_met(32'(cnt_q), GAP_CYCLES);

endmodule

// File: rtl/grant_fsm.sv
module grant_fsm
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cpu_req,
  input  logic       alt_req,
  input  logic       cpu_busy,
  input  logic       cpu_lock,
  input  logic       gap_ok,
  output logic       cpu_grant,
  output logic       alt_grant,
  output logic       window,
  output arb_state_t state
);

  arb_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_CPU:   if (alt_req && !cpu_req && !cpu_lock) nxt = ST_CHECK;
      ST_CHECK, ST_HELD: begin
        if (cpu_lock)                 nxt = ST_CPU;
        else if (cpu_busy)            nxt = ST_HELD;
        else if (!alt_req || cpu_req) nxt = ST_CPU;
        else if (gap_ok)              nxt = ST_ALT;
        else                          nxt = ST_CHECK;
      end
      ST_ALT:   if (!alt_req) nxt = ST_GAP;
      ST_GAP:   if (gap_ok)   nxt = ST_CPU;
      default:  nxt = ST_CPU;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_CPU;
    else     state <= nxt;
  end

  always_comb begin
    cpu_grant = (state == ST_CPU);
    alt_grant = (state == ST_ALT);
    window    = (state == ST_CHECK) || (state == ST_HELD);
  end

  assert_lock_regrant_R6: assert property (@(posedge clk) disable iff (rst)
    window && cpu_lock |=> cpu_grant && !alt_grant);

  assert_busy_holds_R5: assert property (@(posedge clk) disable iff (rst)
    window && cpu_busy |=> !alt_grant);

  assert_lock_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    cpu_grant && cpu_lock |=> cpu_grant);

endmodule

// File: rtl/bus_arbiter2.sv
module bus_arbiter2
  import arb_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic cpu_req,
  input  logic alt_req,
  input  logic cpu_busy,
  input  logic cpu_tip,
  input  logic cpu_lock,
  input  logic slv_ack,
  input  logic slv_err,
  output logic cpu_grant,
  output logic alt_grant
);

  localparam int unsigned QW = $clog2(GAP_CYCLES + 1) + 1;

  logic       gap_ok;
  logic       window;
  logic       term_edge;
  bus_phase_t phase;
  arb_state_t state;

  dead_time_counter #(.GAP_CYCLES(GAP_CYCLES)) u_gap (
    .clk    (clk),
    .rst    (rst),
    .quiet  (!cpu_grant && !alt_grant),
    .gap_ok (gap_ok)
  );

  grant_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .alt_req   (alt_req),
    .cpu_busy  (cpu_busy),
    .cpu_lock  (cpu_lock),
    .gap_ok    (gap_ok),
    .cpu_grant (cpu_grant),
    .alt_grant (alt_grant),
    .window    (window),
    .state     (state)
  );

  bus_phase_tracker u_phase (
    .cpu_grant (cpu_grant),
    .alt_grant (alt_grant),
    .cpu_busy  (cpu_busy),
    .cpu_tip   (cpu_tip),
    .slv_ack   (slv_ack),
    .slv_err   (slv_err),
    .phase     (phase),
    .term_edge (term_edge)
  );

  // independent count of edges with both grants low, for the gap check
  logic [QW-1:0] quiet_edges;
  always_ff @(posedge clk) begin
    if (rst || cpu_grant || alt_grant) quiet_edges <= '0;
    else if (quiet_edges != QW'(GAP_CYCLES)) quiet_edges <= quiet_edges + 1'b1;
  end

  assert_one_owner_R2: assert property (@(posedge clk) disable iff (rst)
    !(cpu_grant && alt_grant));

  assert_reset_park_R1: assert property (@(posedge clk)
    $past(rst) && !rst |-> cpu_grant && !alt_grant);

  assert_alt_after_idle_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(alt_grant) |-> $past(phase) == PH_IDLE && !$past(cpu_lock));

  assert_term_no_regrant_R5: assert property (@(posedge clk) disable iff (rst)
    term_edge && window && !cpu_lock && !cpu_req && alt_req |=> !cpu_grant);

  assert_alt_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(alt_grant) |-> 32'(quiet_edges) >= GAP_CYCLES);

  assert_cpu_gap_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cpu_grant) && $past(state) == ST_GAP |-> 32'(quiet_edges) >= GAP_CYCLES);

  assert_alt_release_R7: assert property (@(posedge clk) disable iff (rst)
    alt_grant && !alt_req |=> !alt_grant && !cpu_grant);

  assert_park_R3: assert property (@(posedge clk) disable iff (rst)
    cpu_grant && (!alt_req || cpu_req) |=> cpu_grant);

endmodule

// File: tb/bus_arbiter2_test.sv
module bus_arbiter2_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req = 0, alt_req = 0, cpu_busy = 0, cpu_tip = 0;
  logic cpu_lock = 0, slv_ack = 0, slv_err = 0;
  logic cpu_grant, alt_grant;

  int checks = 0;
  int fails = 0;
  int overlap_seen = 0;
  logic prev_cg = 1'b0, prev_ag = 1'b0;

  always #4 clk = ~clk;

  bus_arbiter2 uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .alt_req(alt_req),
    .cpu_busy(cpu_busy), .cpu_tip(cpu_tip), .cpu_lock(cpu_lock),
    .slv_ack(slv_ack), .slv_err(slv_err),
    .cpu_grant(cpu_grant), .alt_grant(alt_grant)
  );

  // one edge, then settle; also watches for owner change without a gap (R8)
  task automatic step();
    @(posedge clk);
    #2;
    if (cpu_grant && alt_grant) overlap_seen++;
    if ((prev_cg && alt_grant) || (prev_ag && cpu_grant)) overlap_seen++;
    prev_cg = cpu_grant;
    prev_ag = alt_grant;
  endtask

  task automatic expect_grants(string tag, logic exp_cg, logic exp_ag);
    checks++;
    if ({cpu_grant, alt_grant} !== {exp_cg, exp_ag}) begin
      fails++;
      $display("FAIL %s: grants cpu/alt = %b%b, expected %b%b",
               tag, cpu_grant, alt_grant, exp_cg, exp_ag);
    end
  endtask

  task automatic quiet_inputs();
    cpu_req = 0; alt_req = 0; cpu_busy = 0; cpu_tip = 0;
    cpu_lock = 0; slv_ack = 0; slv_err = 0;
  endtask

  task automatic t_reset();
    rst = 1; quiet_inputs();
    step(); step();
    rst = 0;
    step();
    expect_grants("R1 after reset", 1, 0);
  endtask

  task automatic t_park();
    step(); step();
    expect_grants("R3 park idle", 1, 0);
    cpu_req = 1; alt_req = 1;
    step(); step(); step();
    expect_grants("R3 processor request wins", 1, 0);
    quiet_inputs();
    step();
  endtask

  task automatic t_release_before_ack();
    cpu_busy = 1; cpu_tip = 1; alt_req = 1;
    step();
    expect_grants("R4 grant removed mid transfer", 0, 0);
    slv_ack = 1;
    step();
    expect_grants("R5 ack after removal, busy still high", 0, 0);
    slv_ack = 0; cpu_busy = 0; cpu_tip = 0;
    step();
    expect_grants("R5 alt granted once busy low", 0, 1);
    alt_req = 0;
    step();
    expect_grants("R7 dead gap after alt", 0, 0);
    step();
    expect_grants("R7 grant back to processor", 1, 0);
  endtask

  task automatic t_followon();
    cpu_busy = 1; cpu_tip = 1; slv_err = 1; alt_req = 1;
    step();
    expect_grants("R4 grant removed on final error edge", 0, 0);
    slv_err = 0;
    step(); step(); step();
    expect_grants("R5 follow-on cycle keeps alt off", 0, 0);
    cpu_busy = 0; cpu_tip = 0;
    step();
    expect_grants("R5 alt after follow-on ends", 0, 1);
    alt_req = 0;
    step(); step();
    expect_grants("R7 return after follow-on case", 1, 0);
  endtask

  task automatic t_lock_in_window();
    cpu_busy = 1; alt_req = 1;
    step();
    expect_grants("R4 window opens", 0, 0);
    cpu_lock = 1;
    step();
    expect_grants("R6 lock re-grants processor", 1, 0);
    step(); step(); step();
    expect_grants("R10 lock holds grant against alt_req", 1, 0);
    cpu_lock = 0; cpu_busy = 0;
    step();
    expect_grants("R4 handover after lock ends", 0, 0);
    step();
    expect_grants("R5 alt after lock released", 0, 1);
    alt_req = 0;
    step(); step();
    expect_grants("R7 back after lock case", 1, 0);
  endtask

  task automatic t_cancel();
    alt_req = 1;
    step();
    expect_grants("R4 window with quiet processor", 0, 0);
    alt_req = 0;
    step();
    expect_grants("R9 cancelled request returns grant", 1, 0);
    alt_req = 1;
    step();
    cpu_req = 1;
    step();
    expect_grants("R9 processor request returns grant", 1, 0);
    quiet_inputs();
    step();
  endtask

  task automatic t_repeat();
    for (int i = 0; i < 4; i++) begin
      alt_req = 1;
      step(); step();
      expect_grants("R8 repeated handover to alt", 0, 1);
      alt_req = 0;
      step();
      expect_grants("R8 gap before return", 0, 0);
      step();
    end
    expect_grants("R8 processor after repeats", 1, 0);
    checks++;
    if (overlap_seen != 0) begin
      fails++;
      $display("FAIL R2/R8: direct owner changes = %0d, expected 0", overlap_seen);
    end
  endtask

  initial begin
    t_reset();
    t_park();
    t_release_before_ack();
    t_followon();
    t_lock_in_window();
    t_cancel();
    t_repeat();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule